// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block sits in front of a memory and arbitrates atomic read-modify-write sequences built from load-linked and conditional-store requests. Requesters are identified by a CPU number together with a thread number. Each request is one of four kinds: load-linked, plain store, conditional store or plain load. The block holds a small table of reservations. Each reservation is one aligned 16-byte line plus the identity of the context that reserved it.

For every request the block decides in the same cycle whether the memory write may go ahead. For a conditional store it also reports success or failure. A load-linked creates or replaces the reservation of its own context. A store that completes removes every reservation on its line, whichever context owns it. Table changes take effect at the next rising clock edge. The write-enable and status outputs are purely combinational from the request and the current table.

Top module: `llsc_monitor`

## Requirements
- R1: Addresses are compared at 16-byte granularity: the low 4 address bits are ignored, so a conditional store to any byte of a reserved line hits the reservation.
- R2: A synchronous active-high `rst` invalidates every reservation, so a conditional store after reset fails even if a load-linked preceded the reset.
- R3: With an empty table a conditional store (`req_kind` = 2'b10) fails: `wr_en` = 0 and `sc_ok` = 0.
- R4: A plain store (`req_kind` = 2'b01) always drives `wr_en` = 1 and `sc_ok` = 0.
- R5: A conditional store succeeds (`wr_en` = 1, `sc_ok` = 1) only if a reservation exists on its line whose CPU number and thread number both equal the requester's. A match on only one of the two fields fails with both outputs 0.
- R6: A successful conditional store removes every reservation on its line, including those held by other contexts.
- R7: A plain store removes every reservation on its line, for all contexts.
- R8: A failed conditional store leaves the table unchanged.
- R9: A load-linked (`req_kind` = 2'b00) from a context replaces that context's earlier reservation, so each context holds at most one reservation.
- R10: When all ENTRIES slots are in use, a load-linked from a context without a reservation evicts the least recently inserted reservation.
- R11: Load-linked and plain-load (`req_kind` = 2'b11) requests, and cycles with `req_valid` = 0, drive `wr_en` = 0 and `sc_ok` = 0. A plain load does not change the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for this cycle |
| req_kind | input | 2 | 00 load-linked, 01 store, 10 conditional store, 11 plain load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_cpu | input | CPU_W | CPU number of the requester |
| req_thread | input | THR_W | Thread number of the requester |
| wr_en | output | 1 | Memory write permitted this cycle |
| sc_ok | output | 1 | Conditional store succeeded this cycle |

## Verification
A corrupted reservation entry or age rank does not show at the ports until a conditional store probes that line. It can then show as a spurious success or as a missing one. When the rank order is wrong, the effect stays hidden until the table fills and an eviction removes the wrong context. That can be many requests later. The bench therefore compares both outputs on every cycle against a queue-based model. It also forces full-table eviction and cross-context clearing so that stale state reaches the ports within a few requests.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;

    typedef enum logic [1:0] {
        KIND_LL    = 2'b00,
        KIND_STORE = 2'b01,
        KIND_COND  = 2'b10,
        KIND_LOAD  = 2'b11
    } llsc_kind_e;

    typedef struct packed {
        logic wr;
        logic ok;
        logic ins;
        logic clr;
    } llsc_act_t;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/llsc_match.sv
`timescale 1ns/1ps
module llsc_match #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int CPU_W   = 2,
    parameter int THR_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [ENTRIES-1:0]               vld,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   addrs,
    input  logic [ENTRIES-1:0][CPU_W-1:0]    cpus,
    input  logic [ENTRIES-1:0][THR_W-1:0]    thrs,
    input  logic [ADDR_W-1:0]                q_addr,
    input  logic [CPU_W-1:0]                 q_cpu,
    input  logic [THR_W-1:0]                 q_thr,
    output logic [ENTRIES-1:0]               addr_hit,
    output logic [ENTRIES-1:0]               own_hit
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign addr_hit[i] = vld[i] && (addrs[i] == q_addr);
        assign own_hit[i]  = vld[i] && (cpus[i] == q_cpu) && (thrs[i] == q_thr);
    end

    // R9: a context never owns two entries
    assert_one_per_ctx_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(own_hit) <= 1);

endmodule

// File: rtl/llsc_victim.sv
`timescale 1ns/1ps
module llsc_victim #(
    parameter int ENTRIES = 8,
    parameter int AGE_W   = 3,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0]             own_hit,
    input  logic [ENTRIES-1:0][AGE_W-1:0]  ages,
    output logic [IDX_W-1:0]               tgt,
    output logic [AGE_W:0]                 thresh
);

    logic [ENTRIES-1:0] oldest;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_old
        assign oldest[i] = vld[i] && (ages[i] == AGE_W'(ENTRIES - 1));
    end

    always_comb begin
        tgt    = '0;
        thresh = (AGE_W + 1)'(ENTRIES);
        if (|own_hit) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (own_hit[i]) begin
                    tgt    = IDX_W'(i);
                    thresh = {1'b0, ages[i]};
                end
            end
        end else if (!(&vld)) begin
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (!vld[i]) tgt = IDX_W'(i);
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (oldest[i]) tgt = IDX_W'(i);
            end
        end
    end

    // R10: a full table has exactly one oldest entry to evict
    assert_oldest_unique_R10: assert property (@(posedge clk) disable iff (rst)
        (&vld) |-> $onehot(oldest));

endmodule

// File: rtl/llsc_table.sv
`timescale 1ns/1ps
module llsc_table #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int CPU_W   = 2,
    parameter int THR_W   = 2,
    parameter int AGE_W   = 3,
    parameter int IDX_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             insert,
    input  logic                             clear,
    input  logic [IDX_W-1:0]                 tgt,
    input  logic [AGE_W:0]                   thresh,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [CPU_W-1:0]                 wr_cpu,
    input  logic [THR_W-1:0]                 wr_thr,
    input  logic [ENTRIES-1:0]               clr_vec,
    output logic [ENTRIES-1:0]               vld,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   addrs,
    output logic [ENTRIES-1:0][CPU_W-1:0]    cpus,
    output logic [ENTRIES-1:0][THR_W-1:0]    thrs,
    output logic [ENTRIES-1:0][AGE_W-1:0]    ages
);

    logic [ENTRIES-1:0][AGE_W-1:0] dec;

    // number of removed entries younger than each survivor keeps ranks dense
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            dec[i] = '0;
            for (int j = 0; j < ENTRIES; j++) begin
                if (clr_vec[j] && vld[j] && (ages[j] < ages[i]))
                    dec[i] = dec[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            for (int i = 0; i < ENTRIES; i++) ages[i] <= '0;
        end else if (insert) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == tgt) begin
                    vld[i]   <= 1'b1;
                    addrs[i] <= wr_addr;
                    cpus[i]  <= wr_cpu;
                    thrs[i]  <= wr_thr;
                    ages[i]  <= '0;
                end else if (vld[i] && ({1'b0, ages[i]} < thresh)) begin
                    ages[i]  <= ages[i] + 1'b1;
                end
            end
        end else if (clear) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (clr_vec[i]) vld[i]  <= 1'b0;
                else            ages[i] <= ages[i] - dec[i];
            end
        end
    end

    logic              chk_pend;
    logic [ADDR_W-1:0] chk_addr;
    logic              stale;

    always_ff @(posedge clk) begin
        chk_pend <= !rst && clear;
        chk_addr <= wr_addr;
    end

    always_comb begin
        stale = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            if (vld[i] && (addrs[i] == chk_addr)) stale = 1'b1;
    end

    // R7 / R6: after a completed store no reservation on that line survives
    assert_line_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        chk_pend |-> !stale);

endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int ADDR_W    = 32,
    parameter int CPU_W     = 2,
    parameter int THR_W     = 2,
    parameter int GRAN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [THR_W-1:0]  req_thread,
    output logic              wr_en,
    output logic              sc_ok
);

    localparam int IDX_W = idx_bits(ENTRIES);
    localparam int AGE_W = idx_bits(ENTRIES);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << GRAN_BITS) - 1);

    logic [ADDR_W-1:0]               line_addr;
    logic [ENTRIES-1:0]              vld, addr_hit, own_hit;
    logic [ENTRIES-1:0][ADDR_W-1:0]  addrs;
    logic [ENTRIES-1:0][CPU_W-1:0]   cpus;
    logic [ENTRIES-1:0][THR_W-1:0]   thrs;
    logic [ENTRIES-1:0][AGE_W-1:0]   ages;
    logic [IDX_W-1:0]                tgt;
    logic [AGE_W:0]                  thresh;
    logic                            sc_hit;
    llsc_kind_e                      kind;
    llsc_act_t                       act;

    assign line_addr = req_addr & ~LOW_MASK;
    assign kind      = llsc_kind_e'(req_kind);
    assign sc_hit    = |(addr_hit & own_hit);

    always_comb begin
        act = '0;
        if (req_valid) begin
            unique case (kind)
                KIND_LL:    act.ins = 1'b1;
                KIND_STORE: begin act.wr = 1'b1; act.clr = 1'b1; end
                KIND_COND:  begin
                    act.wr  = sc_hit;
                    act.ok  = sc_hit;
                    act.clr = sc_hit;
                end
                default:    act = '0;
            endcase
        end
    end

    assign wr_en = act.wr;
    assign sc_ok = act.ok;

    llsc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CPU_W(CPU_W), .THR_W(THR_W)) u_match (
        .clk(clk), .rst(rst), .vld(vld), .addrs(addrs), .cpus(cpus), .thrs(thrs),
        .q_addr(line_addr), .q_cpu(req_cpu), .q_thr(req_thread),
        .addr_hit(addr_hit), .own_hit(own_hit)
    );

    llsc_victim #(.ENTRIES(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst(rst), .vld(vld), .own_hit(own_hit), .ages(ages),
        .tgt(tgt), .thresh(thresh)
    );

    llsc_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CPU_W(CPU_W), .THR_W(THR_W),
                 .AGE_W(AGE_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst), .insert(act.ins), .clear(act.clr), .tgt(tgt),
        .thresh(thresh), .wr_addr(line_addr), .wr_cpu(req_cpu), .wr_thr(req_thread),
        .clr_vec(addr_hit), .vld(vld), .addrs(addrs), .cpus(cpus), .thrs(thrs),
        .ages(ages)
    );

    // R5: a status of success always comes with a write
    assert_ok_has_write_R5: assert property (@(posedge clk) disable iff (rst)
        sc_ok |-> wr_en);

    // R11: nothing is written without a request
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!wr_en && !sc_ok));

    // R2: the first cycle after reset has an empty table
    assert_reset_empty_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sc_ok);

endmodule

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;

    localparam int ENTRIES = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b11;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_cpu = '0;
    logic [1:0]  req_thread = '0;
    logic        wr_en, sc_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    llsc_monitor u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_cpu(req_cpu), .req_thread(req_thread),
        .wr_en(wr_en), .sc_ok(sc_ok)
    );

    typedef struct {
        int unsigned line;
        int          cpu;
        int          thr;
    } resv_t;

    resv_t q[$];

    function automatic void purge(input int unsigned line);
        for (int i = q.size() - 1; i >= 0; i--)
            if (q[i].line == line) q.delete(i);
    endfunction

    function automatic void model(input int kind, input int unsigned line, input int c,
                                  input int t, input bit v, output bit wr, output bit ok);
        resv_t n;
        wr = 0;
        ok = 0;
        if (!v) return;
        case (kind)
            0: begin
                for (int i = 0; i < q.size(); i++)
                    if (q[i].cpu == c && q[i].thr == t) begin q.delete(i); break; end
                if (q.size() == ENTRIES) q.delete(0);
                n.line = line; n.cpu = c; n.thr = t;
                q.push_back(n);
            end
            1: begin wr = 1; purge(line); end
            2: begin
                foreach (q[i])
                    if (q[i].line == line && q[i].cpu == c && q[i].thr == t) ok = 1;
                if (ok) begin wr = 1; purge(line); end
            end
            default: ;
        endcase
    endfunction

    task automatic step(input int kind, input int unsigned addr, input int c, input int t,
                        input string tag, input bit v = 1);
        bit ew, eo;
        @(negedge clk);
        req_valid  = v;
        req_kind   = 2'(kind);
        req_addr   = addr;
        req_cpu    = 2'(c);
        req_thread = 2'(t);
        #1;
        model(kind, addr >> 4, c, t, v, ew, eo);
        checks++;
        if (wr_en !== ew || sc_ok !== eo) begin
            errors++;
            $display("FAIL %s kind=%0d addr=%h ctx=%0d/%0d: wr_en=%b sc_ok=%b expected wr_en=%b sc_ok=%b",
                     tag, kind, addr, c, t, wr_en, sc_ok, ew, eo);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        q.delete();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3: empty table, conditional store fails
        step(2, 32'h100, 0, 0, "R3");
        step(0, 32'h100, 0, 0, "R11", 0);
        // R1: reserve one byte, store-conditional to another byte of the line
        step(0, 32'h103, 0, 0, "R11");
        step(2, 32'h10C, 0, 0, "R1");
        step(2, 32'h100, 0, 0, "R6");

        // R5 / R6: two contexts share a line, first success kills the other
        step(0, 32'h200, 0, 0, "R11");
        step(0, 32'h204, 1, 1, "R11");
        step(2, 32'h200, 1, 1, "R5");
        step(2, 32'h200, 0, 0, "R6");

        // R5 / R8: partial context matches fail and change nothing
        step(0, 32'h300, 1, 0, "R11");
        step(2, 32'h300, 1, 1, "R5");
        step(2, 32'h300, 0, 0, "R5");
        step(2, 32'h300, 1, 0, "R8");

        // R4 / R7: plain store from another context clears the line
        step(0, 32'h400, 0, 0, "R11");
        step(1, 32'h408, 2, 3, "R4");
        step(2, 32'h400, 0, 0, "R7");
        step(1, 32'h9F0, 3, 3, "R4");

        // R9: second load-linked replaces the first
        step(0, 32'h500, 0, 0, "R11");
        step(0, 32'h600, 0, 0, "R11");
        step(2, 32'h500, 0, 0, "R9");
        step(2, 32'h600, 0, 0, "R9");

        // R11: plain load leaves reservation intact
        step(0, 32'h900, 2, 1, "R11");
        step(3, 32'h900, 2, 1, "R11");
        step(3, 32'h900, 0, 0, "R11", 0);
        step(2, 32'h904, 2, 1, "R11");

        // R2: reset drops a live reservation
        step(0, 32'h700, 0, 0, "R11");
        do_reset();
        step(2, 32'h700, 0, 0, "R2");

        // R10: nine contexts into eight slots, the first is evicted
        for (int k = 0; k < 9; k++) step(0, 32'h1000 + k * 16, k >> 2, k & 3, "R11");
        step(2, 32'h1000, 0, 0, "R10");
        step(2, 32'h1010, 0, 1, "R10");
        step(2, 32'h1080, 2, 0, "R10");

        // mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int kd;
            string tg;
            kd = int'($urandom_range(0, 3));
            tg = (kd == 1) ? "R4" : (kd == 2) ? "R5" : "R11";
            step(kd, 32'h8000 + $urandom_range(0, 5) * 16 + $urandom_range(0, 15),
                 int'($urandom_range(0, 2)), int'($urandom_range(0, 2)), tg,
                 $urandom_range(0, 7) != 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule